// File: doc/BRIEF.md
# Package Idle State Resolver

This block gathers the idle level that each core is asking for and turns it into a single idle level for the whole package. The starting point is the shallowest core. The block then applies the rules that promote a package-wide C1 to its reduced-clock variant, C1E. After that it clamps the result against the platform's grant, the platform's allowed ceiling and a configured depth cap. The resolved level is registered on every clock edge.

When the package sits in C1E and the reduced-clock option is turned on, a small sequencer steps the power hardware in order. It first asks for the lowest core clock. It asks for a lower voltage only after the clock hardware has acknowledged. A core that wakes withdraws both requests at once. Entry into C3 or any deeper level produces a one-cycle notification pulse. C1 and C1E stay silent.

Top module: `pkg_idle_resolver`

## Requirements
- R1: Level codes are C0=0, C1=1, C1E=2, C3=3, C6=4 and C7=5. A core that presents code 2 counts as C1 with its hint set, and codes 6 and 7 count as C7. If any core presents 0, or the smallest of grantLevel, allowLevel and depthCap is 0, the package resolves to C0.
- R2: When the shallowest core is at C1 and no promotion applies, the package resolves to C1.
- R3: When every core is at C1 with its hint set, the package resolves to C1E, clamped to the limit.
- R4: When every core is at C1 and autoPromoteEn is 1, the package resolves to C1E, clamped to the limit.
- R5: When every core is at C3 or deeper but the limit (the smallest of grant, allowed and cap) is 1 or 2, the package resolves to C1E.
- R6: In all other cases the package resolves to the smaller of the shallowest core level and the limit, where the limit saturates at 5.
- R7: While cacheActive is 1, a result of C7 is demoted to C6.
- R8: freqLowReq is 1 only while the package is in C1E with c1eEn set. With c1eEn at 0 it stays 0.
- R9: voltLowReq rises on the cycle after freqAck is sampled high while freqLowReq is 1. It is never 1 without freqLowReq.
- R10: Any core presenting C0 drops freqLowReq and voltLowReq in that same cycle, before the next clock edge.
- R11: notifyStrobe pulses for one cycle together with the first cycle of a new level of C3 or deeper. It never pulses for C1 or C1E, or while the level stays the same.
- R12: After reset, pkgState is C0 and every output is 0. pkgState follows its inputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| coreReq | input | NUM_CORES*3 | Requested idle level per core, core i in bits [3i+2:3i] |
| coreHint | input | NUM_CORES | Per-core hint asking for C1E when the core is in C1 |
| grantLevel | input | 3 | Deepest level the platform currently grants |
| allowLevel | input | 3 | Deepest level the platform allows at all |
| depthCap | input | 3 | Configured cap on package depth |
| autoPromoteEn | input | 1 | Promote an all-C1 package to C1E |
| c1eEn | input | 1 | Enable the clock and voltage steps in C1E |
| cacheActive | input | 1 | Shared cache still active; blocks C7 |
| freqAck | input | 1 | Clock hardware has reached the lowest frequency |
| pkgState | output | 3 | Registered package level |
| freqLowReq | output | 1 | Request for the lowest core clock |
| voltLowReq | output | 1 | Request for reduced voltage |
| notifyStrobe | output | 1 | One-cycle pulse on entry to C3 or deeper |

## Verification
The hardest situation to reach is a wake that arrives in the middle of the C1E sequence. It needs the voltage request already raised and a core then going to C0 between two clock edges. A directed sequence builds this step by step. It first brings every core to hinted C1 with the reduced-clock option on, then holds the acknowledge low for several cycles and checks that no voltage request appears. It then raises the acknowledge and, once the voltage request has risen, changes one core to C0 on a falling edge and samples both requests before the next rising edge. The resolution rules themselves are covered by an exhaustive sweep of every code pair for two cores, against every hint, promotion, cache and grant combination, followed by a sweep of cap against allowed level.

// File: rtl/pkg_idle_pkg.sv
`timescale 1ns/1ps
package pkg_idle_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_C0  = 3'd0,
    PS_C1  = 3'd1,
    PS_C1E = 3'd2,
    PS_C3  = 3'd3,
    PS_C6  = 3'd4,
    PS_C7  = 3'd5
  } pkgLevel_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_FREQ = 2'd1,
    SEQ_VOLT = 2'd2
  } seqState_e;

  // datapath -> control
  typedef struct packed {
    logic c1eTarget;
    logic anyWake;
  } resolveFlags_t;

  // control -> top
  typedef struct packed {
    logic freqReq;
    logic voltReq;
  } seqStrobes_t;
endpackage

// File: rtl/pkg_idle_core_decode.sv
`timescale 1ns/1ps
module pkg_idle_core_decode
  import pkg_idle_pkg::*;
(
  input  logic [STATE_W-1:0] rawLevel,
  input  logic               rawHint,
  output logic [STATE_W-1:0] level,
  output logic               hint
);
  localparam logic [STATE_W-1:0] DEEPEST = PS_C7;

  always_comb begin
    if (rawLevel == PS_C1E)      level = PS_C1;
    else if (rawLevel > DEEPEST) level = DEEPEST;
    else                         level = rawLevel;
    hint = rawHint || (rawLevel == PS_C1E);
  end
endmodule

// File: rtl/pkg_idle_resolve_dp.sv
`timescale 1ns/1ps
module pkg_idle_resolve_dp
  import pkg_idle_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CORES*STATE_W-1:0] coreReq,
  input  logic [NUM_CORES-1:0]         coreHint,
  input  logic [STATE_W-1:0]           grantLevel,
  input  logic [STATE_W-1:0]           allowLevel,
  input  logic [STATE_W-1:0]           depthCap,
  input  logic                         autoPromoteEn,
  input  logic                         cacheActive,
  output logic [STATE_W-1:0]           pkgState,
  output logic                         notifyStrobe,
  output resolveFlags_t                flags
);
  localparam logic [STATE_W-1:0] DEEPEST = PS_C7;

  logic [STATE_W-1:0] coreLvl [NUM_CORES];
  logic [NUM_CORES-1:0] coreHnt;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CORES; gi++) begin : g_core
      pkg_idle_core_decode u_dec (
        .rawLevel(coreReq[gi*STATE_W +: STATE_W]),
        .rawHint (coreHint[gi]),
        .level   (coreLvl[gi]),
        .hint    (coreHnt[gi])
      );
    end
  endgenerate

  logic [STATE_W-1:0] minLvl;
  logic               allAtC1;
  logic               allHinted;

  always_comb begin
    minLvl    = DEEPEST;
    allAtC1   = 1'b1;
    allHinted = &coreHnt;
    for (int i = 0; i < NUM_CORES; i++) begin
      if (coreLvl[i] < minLvl) minLvl = coreLvl[i];
      if (coreLvl[i] != PS_C1) allAtC1 = 1'b0;
    end
  end

  logic [STATE_W-1:0] limit;
  always_comb begin
    limit = grantLevel;
    if (allowLevel < limit) limit = allowLevel;
    if (depthCap < limit)   limit = depthCap;
    if (limit > DEEPEST)    limit = DEEPEST;
  end

  logic [STATE_W-1:0] candidate;
  logic [STATE_W-1:0] resolvedNext;
  logic               anyWake;

  assign anyWake = (minLvl == PS_C0);

  always_comb begin
    candidate = minLvl;
    if (minLvl == PS_C1 && allAtC1 && (allHinted || autoPromoteEn))
      candidate = PS_C1E;

    if (anyWake || limit == PS_C0)
      resolvedNext = PS_C0;
    else if (minLvl >= PS_C3 && limit < PS_C3)
      resolvedNext = PS_C1E;
    else if (candidate < limit)
      resolvedNext = candidate;
    else
      resolvedNext = limit;

    if (resolvedNext == PS_C7 && cacheActive)
      resolvedNext = PS_C6;
  end

  logic [STATE_W-1:0] stateQ;
  logic               notifyQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= PS_C0;
      notifyQ <= 1'b0;
    end else begin
      stateQ  <= resolvedNext;
      notifyQ <= (resolvedNext != stateQ) && (resolvedNext >= PS_C3);
    end
  end

  assign pkgState        = stateQ;
  assign notifyStrobe    = notifyQ;
  assign flags.c1eTarget = (resolvedNext == PS_C1E);
  assign flags.anyWake   = anyWake;

  assert_notify_deep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    notifyStrobe |-> (pkgState >= PS_C3));

  assert_cache_blocks_c7_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cacheActive) |-> (pkgState != PS_C7));

  assert_wake_to_c0_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(anyWake) |-> (pkgState == PS_C0));

  assert_within_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pkgState <= $past(limit)) || (pkgState == PS_C1E));
endmodule

// File: rtl/pkg_idle_seq_ctrl.sv
`timescale 1ns/1ps
module pkg_idle_seq_ctrl
  import pkg_idle_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  resolveFlags_t      flags,
  input  logic               c1eEn,
  input  logic               freqAck,
  input  logic [STATE_W-1:0] pkgState,
  output seqStrobes_t        strobes
);
  seqState_e seqQ, seqD;
  logic      stay;

  assign stay = flags.c1eTarget && c1eEn && !flags.anyWake;

  always_comb begin
    seqD = seqQ;
    unique case (seqQ)
      SEQ_IDLE: if (stay) seqD = SEQ_FREQ;
      SEQ_FREQ: begin
        if (!stay)        seqD = SEQ_IDLE;
        else if (freqAck) seqD = SEQ_VOLT;
      end
      SEQ_VOLT: if (!stay) seqD = SEQ_IDLE;
      default:  seqD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seqQ <= SEQ_IDLE;
    else        seqQ <= seqD;
  end

  assign strobes.freqReq = (seqQ != SEQ_IDLE) && !flags.anyWake;
  assign strobes.voltReq = (seqQ == SEQ_VOLT) && !flags.anyWake;

  assert_volt_needs_freq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.voltReq |-> strobes.freqReq);

  assert_volt_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobes.voltReq) |-> $past(freqAck));

  assert_freq_only_c1e_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.freqReq |-> (pkgState == PS_C1E));
endmodule

// File: rtl/pkg_idle_resolver.sv
`timescale 1ns/1ps
module pkg_idle_resolver
  import pkg_idle_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CORES*STATE_W-1:0] coreReq,
  input  logic [NUM_CORES-1:0]         coreHint,
  input  logic [STATE_W-1:0]           grantLevel,
  input  logic [STATE_W-1:0]           allowLevel,
  input  logic [STATE_W-1:0]           depthCap,
  input  logic                         autoPromoteEn,
  input  logic                         c1eEn,
  input  logic                         cacheActive,
  input  logic                         freqAck,
  output logic [STATE_W-1:0]           pkgState,
  output logic                         freqLowReq,
  output logic                         voltLowReq,
  output logic                         notifyStrobe
);
  resolveFlags_t flags;
  seqStrobes_t   strobes;

  pkg_idle_resolve_dp #(.NUM_CORES(NUM_CORES)) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .coreReq      (coreReq),
    .coreHint     (coreHint),
    .grantLevel   (grantLevel),
    .allowLevel   (allowLevel),
    .depthCap     (depthCap),
    .autoPromoteEn(autoPromoteEn),
    .cacheActive  (cacheActive),
    .pkgState     (pkgState),
    .notifyStrobe (notifyStrobe),
    .flags        (flags)
  );

  pkg_idle_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .c1eEn   (c1eEn),
    .freqAck (freqAck),
    .pkgState(pkgState),
    .strobes (strobes)
  );

  assign freqLowReq = strobes.freqReq;
  assign voltLowReq = strobes.voltReq;
endmodule

// File: tb/pkg_idle_resolver_bench.sv
`timescale 1ns/1ps
module pkg_idle_resolver_bench;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC*3-1:0] coreReq = '0;
  logic [NC-1:0] coreHint = '0;
  logic [2:0]    grantLevel = 3'd7, allowLevel = 3'd7, depthCap = 3'd7;
  logic          autoPromoteEn = 1'b0, c1eEn = 1'b0, cacheActive = 1'b0, freqAck = 1'b0;
  logic [2:0]    pkgState;
  logic          freqLowReq, voltLowReq, notifyStrobe;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int prevExp = 0;

  always #2.5 clk = ~clk;

  pkg_idle_resolver #(.NUM_CORES(NC)) u_pkg_idle_resolver (
    .clk(clk), .rst_n(rst_n), .coreReq(coreReq), .coreHint(coreHint),
    .grantLevel(grantLevel), .allowLevel(allowLevel), .depthCap(depthCap),
    .autoPromoteEn(autoPromoteEn), .c1eEn(c1eEn), .cacheActive(cacheActive),
    .freqAck(freqAck), .pkgState(pkgState), .freqLowReq(freqLowReq),
    .voltLowReq(voltLowReq), .notifyStrobe(notifyStrobe)
  );

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  function automatic int lvlOf(input int v);
    if (v == 2) return 1;
    if (v > 5) return 5;
    return v;
  endfunction

  // expected level and the requirement that decides it
  function automatic int model(input int a, input int b, input int ha, input int hb,
                               input int au, input int gr, input int al, input int cp,
                               input int ca, output string tag);
    int la, lb, m, lim, cand, r;
    bit hintA, hintB, promo;
    la = lvlOf(a); lb = lvlOf(b);
    hintA = (ha != 0) || (a == 2);
    hintB = (hb != 0) || (b == 2);
    m = (la < lb) ? la : lb;
    lim = gr;
    if (al < lim) lim = al;
    if (cp < lim) lim = cp;
    if (lim > 5) lim = 5;
    promo = (la == 1) && (lb == 1) && ((hintA && hintB) || au != 0);
    if (m == 0 || lim == 0) begin r = 0; tag = "R1"; end
    else if (m >= 3 && lim < 3) begin r = 2; tag = "R5"; end
    else begin
      cand = promo ? 2 : m;
      r = (cand < lim) ? cand : lim;
      if (r == 2) tag = (hintA && hintB) ? "R3" : "R4";
      else if (r == 1) tag = "R2";
      else tag = "R6";
    end
    if (r == 5 && ca != 0) begin r = 4; tag = "R7"; end
    return r;
  endfunction

  task automatic applyStep(input int a, input int b, input int ha, input int hb,
                           input int au, input int gr, input int al, input int cp,
                           input int ca);
    string tag;
    int e;
    @(negedge clk);
    coreReq = {b[2:0], a[2:0]};
    coreHint = {hb[0], ha[0]};
    autoPromoteEn = au[0]; grantLevel = gr[2:0]; allowLevel = al[2:0];
    depthCap = cp[2:0]; cacheActive = ca[0];
    e = model(a, b, ha, hb, au, gr, al, cp, ca, tag);
    @(posedge clk); #1;
    check(tag, int'(pkgState), e);
    check("R11", int'(notifyStrobe), (e != prevExp && e >= 3) ? 1 : 0);
    check("R8", int'(freqLowReq), 0);
    prevExp = e;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    check("R12", int'(pkgState), 0);
    check("R12", int'(freqLowReq | voltLowReq | notifyStrobe), 0);
    @(negedge clk); rst_n = 1'b1;

    // R12 one-edge latency
    @(negedge clk);
    coreReq = {3'd3, 3'd3};
    #1 check("R12", int'(pkgState), 0);
    @(posedge clk); #1 check("R12", int'(pkgState), 3);
    prevExp = 3;

    // exhaustive sweep: R1..R7, R11
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int h = 0; h < 4; h++)
          for (int au = 0; au < 2; au++)
            for (int ca = 0; ca < 2; ca++)
              for (int gr = 0; gr < 8; gr++)
                applyStep(a, b, h & 1, h >> 1, au, gr, 7, 7, ca);

    // cap against allowed level
    for (int cp = 0; cp < 8; cp++)
      for (int al = 0; al < 8; al++)
        for (int s = 0; s < 4; s++)
          applyStep((s == 0) ? 1 : s + 2, 5, 0, 0, s & 1, 7, al, cp, 0);

    // C1E sequencing: R8, R9, R10
    applyStep(0, 0, 0, 0, 0, 7, 7, 7, 0);
    @(negedge clk);
    c1eEn = 1'b1; coreReq = {3'd1, 3'd1}; coreHint = 2'b11;
    @(posedge clk); #1;
    check("R8", int'(pkgState), 2);
    check("R8", int'(freqLowReq), 1);
    check("R11", int'(notifyStrobe), 0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check("R9", int'(voltLowReq), 0);
      check("R8", int'(freqLowReq), 1);
    end
    @(negedge clk); freqAck = 1'b1;
    #1 check("R9", int'(voltLowReq), 0);
    @(posedge clk); #1;
    check("R9", int'(voltLowReq), 1);
    check("R9", int'(freqLowReq), 1);
    @(negedge clk); freqAck = 1'b0; coreReq = {3'd1, 3'd0};
    #1;
    check("R10", int'(freqLowReq), 0);
    check("R10", int'(voltLowReq), 0);
    @(posedge clk); #1;
    check("R10", int'(pkgState), 0);
    check("R10", int'(freqLowReq | voltLowReq), 0);

    // c1eEn low: C1E without requests
    @(negedge clk); c1eEn = 1'b0; coreReq = {3'd2, 3'd2};
    repeat (2) @(posedge clk);
    #1;
    check("R8", int'(pkgState), 2);
    check("R8", int'(freqLowReq), 0);

    finishRun();
  end
endmodule